// File: doc/BRIEF.md
# Dual-Width Arithmetic Status Flag Unit

This block sits beside the adder of a small CPU datapath and keeps two status flags: an overflow flag and a negative flag. A run-time mode input picks the data length. In wide mode the whole 16-bit word takes part in the operation. In narrow mode only the low byte takes part, and the upper byte of the first operand passes through to the result unchanged. Each cycle the block takes an operation select, two operands and a carry-in. It produces the result combinationally and updates the flags at the next clock edge.

Two masked commands let instruction-level code force flags directly. A set command drives each selected flag to 1. A clear command drives each selected flag to 0. When a command is present, the block ignores the arithmetic update to the flags in that cycle. When no operation and no command is requested, the flags hold their value.

Top module: `sflag_unit`

## Requirements
- R1: After a cycle with `rst` high at a clock edge, both `flag_v` and `flag_n` read 0.
- R2: With `op_sel` = 2'b01 (add) and `narrow_mode` = 0, `result` equals `opnd_a + opnd_b + carry_in` modulo 2^16.
- R3: In wide mode, after an add or subtract with no command, `flag_v` is 1 exactly when the true signed result lies outside -32768..+32767.
- R4: In narrow mode with add or subtract, `result[7:0]` is the low-byte sum or difference and `result[15:8]` equals `opnd_a[15:8]`.
- R5: In narrow mode, after an add or subtract with no command, `flag_v` is 1 exactly when the true signed result of the low bytes lies outside -128..+127.
- R6: After an add, subtract or pass with no command, `flag_n` equals bit 15 of `result` in wide mode and bit 7 in narrow mode.
- R7: With `op_sel` = 2'b11 (pass), `result` equals `opnd_a`, and `flag_v` keeps its value.
- R8: With `op_sel` = 2'b10 (subtract), `result` equals `opnd_a - opnd_b - 1 + carry_in` at the active width, so that `carry_in` = 1 means no borrow.
- R9: With `op_sel` = 2'b00 (hold) and no command, both flags keep their values, and `result` equals `opnd_a`.
- R10: In both mask inputs, bit 1 selects V and bit 0 selects N. A set command forces each selected flag to 1, and a clear command forces each selected flag to 0. When both commands select the same flag, set wins. Flags that neither command selects keep their value.
- R11: When `set_en` or `clr_en` is high, the add, subtract or pass in that cycle does not change either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 2 | 00 hold, 01 add, 10 subtract, 11 pass |
| narrow_mode | input | 1 | 1 selects 8-bit data length, 0 selects 16-bit |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into add, not-borrow into subtract |
| set_en | input | 1 | Set-flags command strobe |
| set_mask | input | 2 | Flags to set: bit 1 V, bit 0 N |
| clr_en | input | 1 | Clear-flags command strobe |
| clr_mask | input | 2 | Flags to clear: bit 1 V, bit 0 N |
| result | output | 16 | Combinational operation result |
| flag_v | output | 1 | Registered overflow flag |
| flag_n | output | 1 | Registered negative flag |

## Verification
The bench drives operands to the signed limits at both widths, for example 0x7FFF+1, 0x8000-1 and 0x7F+1 in narrow mode with nonzero upper bytes. A design that detected overflow at the wrong bit, or that let the upper byte take part in narrow arithmetic, would report the wrong V or corrupt `result[15:8]`. Other directed steps do a pass after V was set, a set and a clear on the same flag, and a command in the same cycle as an overflowing add. A design that cleared V on a pass, let clear win over set, or let arithmetic override a command would show the wrong flag value in the cycle after. Random mixed traffic then compares every result and both flags against a model built from signed integer arithmetic.

// File: rtl/sflag_pkg.sv
package sflag_pkg;
   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_ADD  = 2'd1,
      OP_SUB  = 2'd2,
      OP_PASS = 2'd3
   } sflag_op_e;

   localparam int FLAG_N_BIT = 0;
   localparam int FLAG_V_BIT = 1;
   localparam int FLAG_CNT   = 2;
endpackage

// File: rtl/sflag_arith.sv
module sflag_arith #(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   input  logic              do_sub,
   input  logic              do_arith,
   input  logic              narrow,
   output logic [DATA_W-1:0] res,
   output logic              a_sgn,
   output logic              b_sgn,
   output logic              r_sgn
);
   logic [DATA_W-1:0]   b_eff;
   logic [DATA_W-1:0]   sum_wide;
   logic [NARROW_W-1:0] sum_low;
   logic [DATA_W-1:0]   sum_sel;

   assign b_eff    = do_sub ? ~b : b;
   assign sum_wide = a + b_eff + {{(DATA_W-1){1'b0}}, cin};
   assign sum_low  = a[NARROW_W-1:0] + b_eff[NARROW_W-1:0]
                   + {{(NARROW_W-1){1'b0}}, cin};

   generate
      if (DATA_W > NARROW_W) begin : g_split
         assign sum_sel = narrow ? {a[DATA_W-1:NARROW_W], sum_low} : sum_wide;
      end else begin : g_same
         assign sum_sel = sum_wide;
      end
   endgenerate

   assign res   = do_arith ? sum_sel : a;
   assign a_sgn = narrow ? a[NARROW_W-1]     : a[DATA_W-1];
   assign b_sgn = narrow ? b_eff[NARROW_W-1] : b_eff[DATA_W-1];
   assign r_sgn = narrow ? res[NARROW_W-1]   : res[DATA_W-1];
endmodule

// File: rtl/sflag_judge.sv
module sflag_judge (
   input  logic a_sgn,
   input  logic b_sgn,
   input  logic r_sgn,
   output logic ovf,
   output logic neg
);
   always_comb begin
      ovf = (a_sgn == b_sgn) && (r_sgn != a_sgn);
      neg = r_sgn;
   end
endmodule

// File: rtl/sflag_store.sv
module sflag_store
   import sflag_pkg::*;
(
   input  logic                clk,
   input  logic                rst,
   input  logic                upd_v,
   input  logic                upd_n,
   input  logic                ovf,
   input  logic                neg,
   input  logic                set_en,
   input  logic [FLAG_CNT-1:0] set_mask,
   input  logic                clr_en,
   input  logic [FLAG_CNT-1:0] clr_mask,
   output logic [FLAG_CNT-1:0] flags
);
   logic [FLAG_CNT-1:0] arith_val;
   logic [FLAG_CNT-1:0] arith_upd;
   logic [FLAG_CNT-1:0] set_sel;
   logic [FLAG_CNT-1:0] clr_sel;
   logic                cmd_any;

   always_comb begin
      arith_val             = '0;
      arith_upd             = '0;
      arith_val[FLAG_V_BIT] = ovf;
      arith_val[FLAG_N_BIT] = neg;
      arith_upd[FLAG_V_BIT] = upd_v;
      arith_upd[FLAG_N_BIT] = upd_n;
      set_sel               = set_en ? set_mask : '0;
      clr_sel               = clr_en ? clr_mask : '0;
      cmd_any               = set_en | clr_en;
   end

   generate
      for (genvar i = 0; i < FLAG_CNT; i++) begin : g_flag
         always_ff @(posedge clk) begin
            if (rst)             flags[i] <= 1'b0;
            else if (cmd_any) begin
               if (set_sel[i])      flags[i] <= 1'b1;
               else if (clr_sel[i]) flags[i] <= 1'b0;
            end
            else if (arith_upd[i]) flags[i] <= arith_val[i];
         end
      end
   endgenerate
endmodule

// File: rtl/sflag_unit.sv
module sflag_unit
   import sflag_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        op_sel,
   input  logic              narrow_mode,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic              carry_in,
   input  logic              set_en,
   input  logic [1:0]        set_mask,
   input  logic              clr_en,
   input  logic [1:0]        clr_mask,
   output logic [DATA_W-1:0] result,
   output logic              flag_v,
   output logic              flag_n
);
   initial begin
      assert (NARROW_W >= 2) else $error("NARROW_W must be at least 2");
      assert (NARROW_W <= DATA_W) else $error("NARROW_W must not exceed DATA_W");
   end

   sflag_op_e           op;
   logic                is_arith;
   logic                a_sgn, b_sgn, r_sgn;
   logic                ovf, neg;
   logic [FLAG_CNT-1:0] flags;

   assign op       = sflag_op_e'(op_sel);
   assign is_arith = (op == OP_ADD) || (op == OP_SUB);

   sflag_arith #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_arith (
      .a(opnd_a), .b(opnd_b), .cin(carry_in), .do_sub(op == OP_SUB),
      .do_arith(is_arith), .narrow(narrow_mode), .res(result),
      .a_sgn(a_sgn), .b_sgn(b_sgn), .r_sgn(r_sgn)
   );

   sflag_judge u_judge (
      .a_sgn(a_sgn), .b_sgn(b_sgn), .r_sgn(r_sgn), .ovf(ovf), .neg(neg)
   );

   sflag_store u_store (
      .clk(clk), .rst(rst), .upd_v(is_arith), .upd_n(is_arith || op == OP_PASS),
      .ovf(ovf), .neg(neg), .set_en(set_en), .set_mask(set_mask),
      .clr_en(clr_en), .clr_mask(clr_mask), .flags(flags)
   );

   assign flag_v = flags[FLAG_V_BIT];
   assign flag_n = flags[FLAG_N_BIT];
endmodule

// File: rtl/sflag_unit_chk.sv
module sflag_unit_chk #(
   parameter int DATA_W   = 16,
   parameter int NARROW_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic [1:0]        op_sel,
   input logic              narrow_mode,
   input logic [DATA_W-1:0] opnd_a,
   input logic [DATA_W-1:0] opnd_b,
   input logic              carry_in,
   input logic              set_en,
   input logic [1:0]        set_mask,
   input logic              clr_en,
   input logic [1:0]        clr_mask,
   input logic [DATA_W-1:0] result,
   input logic              flag_v,
   input logic              flag_n
);
   logic rst_seen = 1'b0;
   logic no_cmd;
   assign no_cmd = !set_en && !clr_en;

   always_ff @(posedge clk) rst_seen <= rst;

   // R1: flags are zero after a reset edge
   always @(negedge clk) begin
      if (rst_seen && !rst)
         p_reset_zero_r1: assert (!flag_v && !flag_n);
   end

   p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
      (op_sel == 2'd0 && no_cmd) |=> ($stable(flag_v) && $stable(flag_n)));

   p_pass_keeps_v_r7: assert property (@(posedge clk) disable iff (rst)
      (op_sel == 2'd3 && no_cmd) |=> $stable(flag_v));

   p_set_v_r10: assert property (@(posedge clk) disable iff (rst)
      (set_en && set_mask[1]) |=> flag_v);

   p_clr_n_r10: assert property (@(posedge clk) disable iff (rst)
      (clr_en && clr_mask[0] && !(set_en && set_mask[0])) |=> !flag_n);

   p_cmd_blocks_v_r11: assert property (@(posedge clk) disable iff (rst)
      ((set_en || clr_en) && !(set_en && set_mask[1]) && !(clr_en && clr_mask[1]))
      |=> $stable(flag_v));

   p_upper_kept_r4: assert property (@(posedge clk) disable iff (rst)
      (narrow_mode && (op_sel == 2'd1 || op_sel == 2'd2))
      |-> result[DATA_W-1:NARROW_W] == opnd_a[DATA_W-1:NARROW_W]);

   p_wide_add_ovf_r3: assert property (@(posedge clk) disable iff (rst)
      (!narrow_mode && op_sel == 2'd1 && no_cmd)
      |=> flag_v == $past((opnd_a[DATA_W-1] == opnd_b[DATA_W-1])
                          && (result[DATA_W-1] != opnd_a[DATA_W-1])));
endmodule

bind sflag_unit sflag_unit_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (.*);

// File: tb/sflag_unit_tb.sv
`timescale 1ns/1ps
module sflag_unit_tb;
   logic        clk = 1'b0;
   logic        rst;
   logic [1:0]  op_sel;
   logic        narrow_mode;
   logic [15:0] opnd_a, opnd_b;
   logic        carry_in;
   logic        set_en, clr_en;
   logic [1:0]  set_mask, clr_mask;
   logic [15:0] result;
   logic        flag_v, flag_n;

   int n_cmp = 0;
   int n_bad = 0;
   logic exp_v, exp_n;

   always #2.5 clk = ~clk;

   sflag_unit u_dut (
      .clk(clk), .rst(rst), .op_sel(op_sel), .narrow_mode(narrow_mode),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
      .set_en(set_en), .set_mask(set_mask), .clr_en(clr_en), .clr_mask(clr_mask),
      .result(result), .flag_v(flag_v), .flag_n(flag_n)
   );

   function automatic void model(input logic [1:0] op, input logic nar,
                                 input logic [15:0] a, input logic [15:0] b,
                                 input logic c, output logic [15:0] r,
                                 output logic ov, output logic ng);
      int sa, sb, t;
      if (nar) begin
         sa = int'($signed(a[7:0])); sb = int'($signed(b[7:0]));
      end else begin
         sa = int'($signed(a)); sb = int'($signed(b));
      end
      t = (op == 2'd2) ? sa - sb - 1 + int'(c) : sa + sb + int'(c);
      ov = nar ? (t > 127 || t < -128) : (t > 32767 || t < -32768);
      if (op == 2'd1 || op == 2'd2)
         r = nar ? {a[15:8], 8'(t)} : 16'(t);
      else
         r = a;
      ng = nar ? r[7] : r[15];
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [1:0] op, input logic nar, input logic [15:0] a,
                       input logic [15:0] b, input logic c, input logic se,
                       input logic [1:0] sm, input logic ce, input logic [1:0] cm);
      logic [15:0] r;
      logic ov, ng;
      string rt, vt, nt;
      @(negedge clk);
      op_sel = op; narrow_mode = nar; opnd_a = a; opnd_b = b; carry_in = c;
      set_en = se; set_mask = sm; clr_en = ce; clr_mask = cm;
      model(op, nar, a, b, c, r, ov, ng);
      #1;
      rt = (op == 2'd2) ? "R8" : (op == 2'd3) ? "R7" : (op == 2'd0) ? "R9" : nar ? "R4" : "R2";
      chk({rt, " result"}, result, r);
      if (se || ce) begin
         vt = "R10/R11 V"; nt = "R10/R11 N";
         if (se && sm[1]) exp_v = 1'b1; else if (ce && cm[1]) exp_v = 1'b0;
         if (se && sm[0]) exp_n = 1'b1; else if (ce && cm[0]) exp_n = 1'b0;
      end else begin
         vt = (op == 2'd3) ? "R7 V" : (op == 2'd0) ? "R9 V" : nar ? "R5 V" : "R3 V";
         nt = (op == 2'd0) ? "R9 N" : "R6 N";
         if (op == 2'd1 || op == 2'd2) exp_v = ov;
         if (op != 2'd0) exp_n = ng;
      end
      @(posedge clk); #1;
      chk(vt, 16'(flag_v), 16'(exp_v));
      chk(nt, 16'(flag_n), 16'(exp_n));
   endtask

   initial begin
      #900000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int seed;
      seed = 32'h5F1A6;
      void'($urandom(seed));
      rst = 1'b1; op_sel = 2'd0; narrow_mode = 1'b0; opnd_a = '0; opnd_b = '0;
      carry_in = 1'b0; set_en = 1'b0; clr_en = 1'b0; set_mask = '0; clr_mask = '0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 V", 16'(flag_v), 16'd0);
      chk("R1 N", 16'(flag_n), 16'd0);
      @(negedge clk); rst = 1'b0;
      exp_v = 1'b0; exp_n = 1'b0;

      step(2'd1, 1'b0, 16'h7FFF, 16'h0001, 1'b0, 0, 2'b00, 0, 2'b00); // R3 wide ovf
      step(2'd1, 1'b0, 16'h1234, 16'h0001, 1'b1, 0, 2'b00, 0, 2'b00); // R3 clear
      step(2'd2, 1'b0, 16'h8000, 16'h0001, 1'b1, 0, 2'b00, 0, 2'b00); // R8/R3
      step(2'd3, 1'b0, 16'h0005, 16'h0000, 1'b0, 0, 2'b00, 0, 2'b00); // R7 V held
      step(2'd1, 1'b1, 16'hAB7F, 16'hCD01, 1'b0, 0, 2'b00, 0, 2'b00); // R4/R5
      step(2'd1, 1'b0, 16'h007F, 16'h0001, 1'b0, 0, 2'b00, 0, 2'b00); // R3 no ovf
      step(2'd2, 1'b1, 16'h1280, 16'h3401, 1'b1, 0, 2'b00, 0, 2'b00); // R5 sub
      step(2'd3, 1'b1, 16'h0080, 16'h0000, 1'b0, 0, 2'b00, 0, 2'b00); // R6 narrow
      step(2'd0, 1'b0, 16'h0000, 16'h0000, 1'b0, 0, 2'b00, 0, 2'b00); // R9
      step(2'd0, 1'b0, 16'h0000, 16'h0000, 1'b0, 0, 2'b00, 1, 2'b11); // R10 clear
      step(2'd0, 1'b0, 16'h0000, 16'h0000, 1'b0, 1, 2'b10, 0, 2'b00); // R10 set V
      step(2'd0, 1'b0, 16'h0000, 16'h0000, 1'b0, 1, 2'b01, 1, 2'b11); // R10 set wins
      step(2'd1, 1'b0, 16'h7FFF, 16'h7FFF, 1'b1, 0, 2'b00, 1, 2'b11); // R11 blocked
      step(2'd3, 1'b0, 16'h8000, 16'h0000, 1'b0, 1, 2'b10, 0, 2'b00); // R11 N held

      for (int i = 0; i < 600; i++) begin
         logic [31:0] rnd;
         logic ce, se;
         rnd = $urandom;
         se = (rnd[3:0] == 4'd0);
         ce = (rnd[7:4] == 4'd0);
         step(rnd[9:8], rnd[10], 16'($urandom), 16'($urandom), rnd[11],
              se, rnd[13:12], ce, rnd[15:14]);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule